// File: doc/BRIEF.md
# Compensated Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds. On each reference clock edge where counting is enabled, the value grows by a small programmable step. A separate compensation step can replace that default step to trim the frequency. Two trim mechanisms decide when the compensation step is used:

- a burst count, which uses the compensation step on each of the next K ticks;
- a periodic slow reload, which uses it once every N ticks, indefinitely.

An optional compare-0 match sends the counter back to zero, so the count wraps at a chosen cycle time.

Software reaches the block through a simple 32-bit word-addressed register port with one-cycle write and read strobes. Read data is registered. Reading the low count word copies the high word into a holding register, so a read of the low word followed by a read of the high word returns one coherent 64-bit value. The full count is also driven on a wide output for local timestamp consumers.

Top module: `comp_time_counter`

## Requirements
- R1: After reset the count, every configuration field, both trim counters, the compare settings, the overflow flag, the high-word hold register and the read data are all zero.
- R2: The config word (address 0) holds the run enable in bit 0, the default step in bits 7:4 and the compensation step in bits 19:8, and reads back in that layout. While run is 0, the count and both trim counters hold.
- R3: On every running tick where neither trim mechanism is due, the count grows by the default step.
- R4: The burst register (address 4) keeps only bits 23:0 of a write and reads back the remaining count. While it is nonzero, each running tick adds the compensation step and decrements it by one.
- R5: The slow register (address 5) holds a reload value N and starts the slow counter at N. With N nonzero, every Nth running tick after the write adds the compensation step. A value of 0 disables periodic trimming.
- R6: When a burst tick and a slow expiry fall on the same tick, the count grows by a single compensation step.
- R7: A carry out of bit 63 on an increment sets status bit 0 (address 1). The flag stays set until a write with bit 0 set. A write with bit 0 clear has no effect. A carry in the clearing cycle leaves the flag set.
- R8: The compare config (address 6) has reset-enable in bit 0 and compare-enable in bit 1. The compare value is at address 7 (low word) and address 8 (high word). With both bits set, a running tick on which the count equals the compare value loads zero instead of incrementing.
- R9: A write to the low count word (address 2) or the high count word (address 3) replaces that half at that edge. In that cycle there is no increment, no compare reset and no overflow.
- R10: Read data appears one cycle after the read strobe. A read of address 2 returns the low count and captures the high count into the hold register. A read of address 3 returns that hold register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| time_ns | output | 2*DATA_W | Current 64-bit count |

## Verification
The hardest situations to reach are the coincidences: a burst tick landing on the same tick as a slow expiry, a compare match landing on a cycle with a software write, and a carry out of bit 63. Reaching a carry needs the high word preloaded near all-ones before counting is enabled. Directed sequences set these up exactly, with each run window bounded by enable and disable writes so the number of ticks is known. A long stretch of randomized register traffic with small compare values, short slow periods and preloaded counts then drives these collisions repeatedly. A behavioural model in the bench is compared against the count and the read data on every clock.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int TC_ADDR_W = 4;

    localparam logic [TC_ADDR_W-1:0] ADR_CFG    = 4'd0;
    localparam logic [TC_ADDR_W-1:0] ADR_STAT   = 4'd1;
    localparam logic [TC_ADDR_W-1:0] ADR_CNT_LO = 4'd2;
    localparam logic [TC_ADDR_W-1:0] ADR_CNT_HI = 4'd3;
    localparam logic [TC_ADDR_W-1:0] ADR_BURST  = 4'd4;
    localparam logic [TC_ADDR_W-1:0] ADR_SLOW   = 4'd5;
    localparam logic [TC_ADDR_W-1:0] ADR_CMPCFG = 4'd6;
    localparam logic [TC_ADDR_W-1:0] ADR_CMP_LO = 4'd7;
    localparam logic [TC_ADDR_W-1:0] ADR_CMP_HI = 4'd8;

    // field positions decoded by software
    localparam int CFG_RUN_BIT  = 0;
    localparam int CFG_DEF_LSB  = 4;
    localparam int CFG_COMP_LSB = 8;
    localparam int CMP_RST_BIT  = 0;
    localparam int CMP_EN_BIT   = 1;
    localparam int STAT_OVF_BIT = 0;
endpackage

// File: rtl/tc_trim.sv
module tc_trim #(
    parameter int BURST_W = 24,
    parameter int SLOW_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               burst_wr,
    input  logic [BURST_W-1:0] burst_wdata,
    input  logic               slow_wr,
    input  logic [SLOW_W-1:0]  slow_wdata,
    output logic               use_comp,
    output logic [BURST_W-1:0] burst_left,
    output logic [SLOW_W-1:0]  slow_reload
);
    typedef struct packed {
        logic [BURST_W-1:0] burst;
        logic [SLOW_W-1:0]  reload;
        logic [SLOW_W-1:0]  slow;
    } trim_t;

    trim_t t_d, t_q;
    logic  busy;
    logic  expire;

    always_comb begin
        t_d    = t_q;
        busy   = (t_q.burst != '0);
        expire = (t_q.reload != '0) && (t_q.slow <= SLOW_W'(1));
        use_comp = run && (busy || expire);
        if (run) begin
            if (busy) begin
                t_d.burst = t_q.burst - BURST_W'(1);
            end
            if (t_q.reload != '0) begin
                t_d.slow = expire ? t_q.reload : (t_q.slow - SLOW_W'(1));
            end
        end
        if (burst_wr) begin
            t_d.burst = burst_wdata;
        end
        if (slow_wr) begin
            t_d.reload = slow_wdata;
            t_d.slow   = slow_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign burst_left  = t_q.burst;
    assign slow_reload = t_q.reload;
endmodule

// File: rtl/tc_core.sv
module tc_core #(
    parameter int DATA_W = 32,
    parameter int STEP_W = 12,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [STEP_W-1:0] step,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmp_on,
    input  logic [CNT_W-1:0]  cmp_val,
    input  logic              ovf_clr,
    output logic [CNT_W-1:0]  count,
    output logic              ovf,
    output logic              cmp_hit
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             ovf;
    } core_t;

    core_t          c_d, c_q;
    logic [CNT_W:0] sum;

    always_comb begin
        c_d     = c_q;
        sum     = {1'b0, c_q.count} + (CNT_W + 1)'(step);
        cmp_hit = cmp_on && (c_q.count == cmp_val);
        c_d.ovf = c_q.ovf & ~ovf_clr;
        if (lo_wr || hi_wr) begin
            if (lo_wr) begin
                c_d.count[DATA_W-1:0] = wdata;
            end
            if (hi_wr) begin
                c_d.count[CNT_W-1:DATA_W] = wdata;
            end
        end else if (run) begin
            if (cmp_hit) begin
                c_d.count = '0;
            end else begin
                c_d.count = sum[CNT_W-1:0];
                if (sum[CNT_W]) begin
                    c_d.ovf = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count = c_q.count;
    assign ovf   = c_q.ovf;
endmodule

// File: rtl/comp_time_counter.sv
module comp_time_counter
    import tc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DEF_W   = 4,
    parameter int COMP_W  = 12,
    parameter int BURST_W = 24,
    parameter int SLOW_W  = 32,
    localparam int CNT_W  = 2 * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [TC_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [CNT_W-1:0]     time_ns
);
    typedef struct packed {
        logic              run;
        logic [DEF_W-1:0]  def_inc;
        logic [COMP_W-1:0] comp_inc;
        logic              cmp_rst;
        logic              cmp_en;
        logic [CNT_W-1:0]  cmp0;
        logic [DATA_W-1:0] hi_hold;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t              r_d, r_q;
    logic               run;
    logic               lo_wr;
    logic               hi_wr;
    logic               burst_wr;
    logic               slow_wr;
    logic               ovf_clr;
    logic               use_comp;
    logic               cmp_hit;
    logic               ovf;
    logic [COMP_W-1:0]  step;
    logic [BURST_W-1:0] burst_left;
    logic [SLOW_W-1:0]  slow_reload;
    logic [DATA_W-1:0]  rd_word;

    assign run      = r_q.run;
    assign lo_wr    = reg_wr && (reg_addr == ADR_CNT_LO);
    assign hi_wr    = reg_wr && (reg_addr == ADR_CNT_HI);
    assign burst_wr = reg_wr && (reg_addr == ADR_BURST);
    assign slow_wr  = reg_wr && (reg_addr == ADR_SLOW);
    assign ovf_clr  = reg_wr && (reg_addr == ADR_STAT) && reg_wdata[STAT_OVF_BIT];
    assign step     = use_comp ? r_q.comp_inc : COMP_W'(r_q.def_inc);

    tc_trim #(
        .BURST_W(BURST_W),
        .SLOW_W (SLOW_W)
    ) u_trim (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .burst_wr   (burst_wr),
        .burst_wdata(reg_wdata[BURST_W-1:0]),
        .slow_wr    (slow_wr),
        .slow_wdata (reg_wdata[SLOW_W-1:0]),
        .use_comp   (use_comp),
        .burst_left (burst_left),
        .slow_reload(slow_reload)
    );

    tc_core #(
        .DATA_W(DATA_W),
        .STEP_W(COMP_W)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .step   (step),
        .lo_wr  (lo_wr),
        .hi_wr  (hi_wr),
        .wdata  (reg_wdata),
        .cmp_on (r_q.cmp_en && r_q.cmp_rst),
        .cmp_val(r_q.cmp0),
        .ovf_clr(ovf_clr),
        .count  (time_ns),
        .ovf    (ovf),
        .cmp_hit(cmp_hit)
    );

    always_comb begin
        r_d     = r_q;
        rd_word = '0;
        case (reg_addr)
            ADR_CFG: begin
                rd_word[CFG_RUN_BIT]              = r_q.run;
                rd_word[CFG_DEF_LSB +: DEF_W]     = r_q.def_inc;
                rd_word[CFG_COMP_LSB +: COMP_W]   = r_q.comp_inc;
            end
            ADR_STAT:   rd_word[STAT_OVF_BIT] = ovf;
            ADR_CNT_LO: rd_word = time_ns[DATA_W-1:0];
            ADR_CNT_HI: rd_word = r_q.hi_hold;
            ADR_BURST:  rd_word[BURST_W-1:0] = burst_left;
            ADR_SLOW:   rd_word[SLOW_W-1:0] = slow_reload;
            ADR_CMPCFG: begin
                rd_word[CMP_RST_BIT] = r_q.cmp_rst;
                rd_word[CMP_EN_BIT]  = r_q.cmp_en;
            end
            ADR_CMP_LO: rd_word = r_q.cmp0[DATA_W-1:0];
            ADR_CMP_HI: rd_word = r_q.cmp0[CNT_W-1:DATA_W];
            default:    rd_word = '0;
        endcase
        if (reg_rd) begin
            r_d.rdata = rd_word;
            if (reg_addr == ADR_CNT_LO) begin
                r_d.hi_hold = time_ns[CNT_W-1:DATA_W];
            end
        end
        if (reg_wr) begin
            case (reg_addr)
                ADR_CFG: begin
                    r_d.run      = reg_wdata[CFG_RUN_BIT];
                    r_d.def_inc  = reg_wdata[CFG_DEF_LSB +: DEF_W];
                    r_d.comp_inc = reg_wdata[CFG_COMP_LSB +: COMP_W];
                end
                ADR_CMPCFG: begin
                    r_d.cmp_rst = reg_wdata[CMP_RST_BIT];
                    r_d.cmp_en  = reg_wdata[CMP_EN_BIT];
                end
                ADR_CMP_LO: r_d.cmp0[DATA_W-1:0]     = reg_wdata;
                ADR_CMP_HI: r_d.cmp0[CNT_W-1:DATA_W] = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_rdata = r_q.rdata;
endmodule

// File: rtl/tc_chk.sv
module tc_chk #(
    parameter int CNT_W   = 64,
    parameter int STEP_W  = 12,
    parameter int BURST_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run,
    input logic               lo_wr,
    input logic               hi_wr,
    input logic               cmp_hit,
    input logic [STEP_W-1:0]  step,
    input logic [CNT_W-1:0]   count,
    input logic               ovf,
    input logic               ovf_clr,
    input logic               use_comp,
    input logic               burst_wr,
    input logic [BURST_W-1:0] burst_left
);
    // R2: a stopped counter does not move
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !lo_wr && !hi_wr) |=> $stable(count));

    // R3: a running tick adds the chosen step
    p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !lo_wr && !hi_wr && !cmp_hit) |=>
        (count == $past(count) + CNT_W'($past(step))));

    // R4: a pending burst forces the compensation step
    p_burst_comp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (burst_left != '0)) |-> use_comp);

    // R4: a pending burst shrinks by one per running tick
    p_burst_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (burst_left != '0) && !burst_wr) |=>
        (burst_left == $past(burst_left) - BURST_W'(1)));

    // R7: the overflow flag is sticky until cleared
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R8: a compare match on a running tick lands on zero
    p_cmp_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cmp_hit && !lo_wr && !hi_wr) |=> (count == '0));
endmodule

bind comp_time_counter tc_chk #(
    .CNT_W  (CNT_W),
    .STEP_W (COMP_W),
    .BURST_W(BURST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .lo_wr     (lo_wr),
    .hi_wr     (hi_wr),
    .cmp_hit   (cmp_hit),
    .step      (step),
    .count     (time_ns),
    .ovf       (ovf),
    .ovf_clr   (ovf_clr),
    .use_comp  (use_comp),
    .burst_wr  (burst_wr),
    .burst_left(burst_left)
);

// File: tb/tb_comp_time_counter.sv
module tb_comp_time_counter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] time_ns;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    comp_time_counter dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .time_ns  (time_ns)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference model
    logic        m_run = 0, m_ovf = 0, m_cmprst = 0, m_cmpen = 0, t_comp;
    logic [3:0]  m_def = 0;
    logic [11:0] m_comp = 0;
    logic [23:0] m_burst = 0;
    logic [31:0] m_reload = 0, m_slow = 0, m_hold = 0, m_rdata = 0;
    logic [63:0] m_cnt = 0, m_cmp0 = 0, t_step;
    logic [64:0] t_sum;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_ovf = 0; m_cmprst = 0; m_cmpen = 0; m_def = 0; m_comp = 0;
            m_burst = 0; m_reload = 0; m_slow = 0; m_hold = 0; m_rdata = 0;
            m_cnt = 0; m_cmp0 = 0;
        end else begin
            if (reg_rd) begin
                case (reg_addr)
                    4'd0: m_rdata = {12'h0, m_comp, m_def, 3'b000, m_run};
                    4'd1: m_rdata = {31'h0, m_ovf};
                    4'd2: begin m_rdata = m_cnt[31:0]; m_hold = m_cnt[63:32]; end
                    4'd3: m_rdata = m_hold;
                    4'd4: m_rdata = {8'h0, m_burst};
                    4'd5: m_rdata = m_reload;
                    4'd6: m_rdata = {30'h0, m_cmpen, m_cmprst};
                    4'd7: m_rdata = m_cmp0[31:0];
                    4'd8: m_rdata = m_cmp0[63:32];
                    default: m_rdata = 0;
                endcase
            end
            t_comp = m_run && ((m_burst != 0) || ((m_reload != 0) && (m_slow <= 1)));
            t_step = t_comp ? {52'h0, m_comp} : {60'h0, m_def};
            if (reg_wr && reg_addr == 4'd1 && reg_wdata[0]) m_ovf = 0;
            if (reg_wr && (reg_addr == 4'd2 || reg_addr == 4'd3)) begin
                if (reg_addr == 4'd2) m_cnt[31:0] = reg_wdata;
                else m_cnt[63:32] = reg_wdata;
            end else if (m_run) begin
                if (m_cmprst && m_cmpen && m_cnt == m_cmp0) m_cnt = 0;
                else begin
                    t_sum = {1'b0, m_cnt} + {1'b0, t_step};
                    m_cnt = t_sum[63:0];
                    if (t_sum[64]) m_ovf = 1;
                end
            end
            if (m_run) begin
                if (m_burst != 0) m_burst = m_burst - 1;
                if (m_reload != 0) m_slow = (m_slow <= 1) ? m_reload : m_slow - 1;
            end
            if (reg_wr) begin
                case (reg_addr)
                    4'd0: begin m_run = reg_wdata[0]; m_def = reg_wdata[7:4]; m_comp = reg_wdata[19:8]; end
                    4'd4: m_burst = reg_wdata[23:0];
                    4'd5: begin m_reload = reg_wdata; m_slow = reg_wdata; end
                    4'd6: begin m_cmprst = reg_wdata[0]; m_cmpen = reg_wdata[1]; end
                    4'd7: m_cmp0[31:0] = reg_wdata;
                    4'd8: m_cmp0[63:32] = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 count vs model", time_ns, m_cnt);
            check("R10 rdata vs model", {32'h0, reg_rdata}, {32'h0, m_rdata});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 count after reset", time_ns, 64'd0);
        rd(4'd0, v); check("R1 config after reset", {32'h0, v}, 64'd0);
        rd(4'd1, v); check("R1 status after reset", {32'h0, v}, 64'd0);

        // R2 / R3 default stepping and hold
        wr(4'd0, 32'h0000_0031); idle(5); wr(4'd0, 32'h0000_0030);
        check("R3 six default ticks of 3", time_ns, 64'd18);
        idle(3);
        check("R2 count holds while stopped", time_ns, 64'd18);
        rd(4'd0, v); check("R2 config readback", {32'h0, v}, 64'h30);

        // R4 burst
        wr(4'd2, 32'h0); wr(4'd0, 32'h0000_0720);
        wr(4'd4, 32'hAB00_0005);
        rd(4'd4, v); check("R4 burst keeps 24 bits", {32'h0, v}, 64'd5);
        wr(4'd0, 32'h0000_0721); idle(8); wr(4'd0, 32'h0000_0720);
        check("R4 five comp ticks then default", time_ns, 64'd43);
        rd(4'd4, v); check("R4 burst drained", {32'h0, v}, 64'd0);

        // R5 slow periodic
        wr(4'd2, 32'h0); wr(4'd0, 32'h0000_0520); wr(4'd5, 32'd3);
        wr(4'd0, 32'h0000_0521); idle(8); wr(4'd0, 32'h0000_0520);
        check("R5 every third tick compensated", time_ns, 64'd27);
        rd(4'd5, v); check("R5 reload readback", {32'h0, v}, 64'd3);
        wr(4'd5, 32'd0); wr(4'd2, 32'h0);
        wr(4'd0, 32'h0000_0521); idle(8); wr(4'd0, 32'h0000_0520);
        check("R5 zero disables slow trim", time_ns, 64'd18);

        // R6 coincidence
        wr(4'd2, 32'h0); wr(4'd4, 32'd2); wr(4'd5, 32'd1);
        wr(4'd0, 32'h0000_0521); idle(4); wr(4'd0, 32'h0000_0520);
        check("R6 single comp step per tick", time_ns, 64'd25);
        wr(4'd5, 32'd0);

        // R7 overflow
        wr(4'd0, 32'h0000_0040); wr(4'd3, 32'hFFFF_FFFF); wr(4'd2, 32'hFFFF_FFFE);
        wr(4'd0, 32'h0000_0041); wr(4'd0, 32'h0000_0040);
        check("R7 wrapped count", time_ns, 64'd2);
        rd(4'd1, v); check("R7 overflow set", {32'h0, v}, 64'd1);
        wr(4'd1, 32'h0);
        rd(4'd1, v); check("R7 write of 0 ignored", {32'h0, v}, 64'd1);
        wr(4'd1, 32'h1);
        rd(4'd1, v); check("R7 write of 1 clears", {32'h0, v}, 64'd0);

        // R8 compare reset
        wr(4'd0, 32'h0000_0050); wr(4'd2, 32'h0); wr(4'd3, 32'h0);
        wr(4'd7, 32'd10); wr(4'd8, 32'd0); wr(4'd6, 32'd3);
        wr(4'd0, 32'h0000_0051); idle(7); wr(4'd0, 32'h0000_0050);
        check("R8 wrap at compare value", time_ns, 64'd10);
        wr(4'd6, 32'd2); wr(4'd2, 32'h0);
        wr(4'd0, 32'h0000_0051); idle(7); wr(4'd0, 32'h0000_0050);
        check("R8 no reset without enable bit", time_ns, 64'd40);
        wr(4'd6, 32'd0);

        // R9 software set while running
        wr(4'd0, 32'h0000_0011); idle(2);
        wr(4'd2, 32'h0000_0100);
        check("R9 low write wins over tick", time_ns, 64'h100);
        wr(4'd3, 32'h0000_0007);
        check("R9 high write wins over tick", time_ns, 64'h7_0000_0100);
        wr(4'd0, 32'h0000_0010);

        // R10 coherent read pair
        wr(4'd3, 32'h0); wr(4'd2, 32'hFFFF_FFF8); wr(4'd0, 32'h0000_00F1);
        rd(4'd2, v); check("R10 low word", {32'h0, v}, 64'hFFFF_FFF8);
        rd(4'd3, v); check("R10 high word from hold", {32'h0, v}, 64'd0);
        check("R10 live high already moved", {32'h0, time_ns[63:32]}, 64'd1);
        wr(4'd0, 32'h0);

        // randomized traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [3:0] a;
            logic [31:0] d;
            op = int'($urandom % 4);
            a = 4'($urandom % 10);
            case (a)
                4'd0: d = $urandom;
                4'd1: d = $urandom % 2;
                4'd3: d = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : 32'h0;
                4'd5: d = $urandom % 6;
                4'd7: d = $urandom % 96;
                4'd8: d = 32'h0;
                default: d = $urandom;
            endcase
            if (op == 0) wr(a, d);
            else if (op == 1) rd(a, d);
            else idle(1);
        end
        idle(2);
        finish_run();
    end
endmodule